// File: doc/BRIEF.md
# Byte-Wise Block Move Engine

This block copies bytes from one region of a byte-wide, single-port memory to another. It has two kinds of command. The short command moves a fixed field whose size is given by an 8-bit count. The long command moves a region of up to 16M bytes. It can fill the tail of the destination with a pad byte, or cut the copy off at the destination length. It refuses to run when the operands overlap destructively.

A command is issued by pulsing `start`. `busy` then stays high until the one-cycle `done` pulse, which arrives together with a two-bit completion code. The long command keeps its progress in four architectural registers that are visible at the ports:
- destination address
- destination length
- source address
- source length, together with the pad byte

An interrupt request can stop a long move between two byte transfers. A later `start` with `resume` set then continues the move from the held registers.

Each copied byte costs two cycles: a read from the source, then a write to the destination. Each pad byte costs one write cycle.

Top module: `blkmov_engine`

## Requirements
- R1: A short command with count field N (0..255) copies exactly N+1 bytes from the source to the destination. The byte just past the destination field keeps its old value.
- R2: A short command completes with code 0 and leaves the four architectural registers and the pad byte unchanged.
- R3: A short command ignores `irq`. It runs to its `done` pulse and never raises `irq_ack`.
- R4: A long command whose destination length is zero is legal. It writes no memory and completes with code 0 if the source length is also zero, or code 1 otherwise.
- R5: A long command copies min(dst_len, src_len) bytes in ascending address order. At completion the destination address has advanced by the original destination length and the destination length is zero. The source address has advanced, and the source length has shrunk, by the number of bytes copied.
- R6: When the destination length exceeds the source length, the remaining destination bytes are written with the pad byte. The completion code is 2.
- R7: When the source length exceeds the destination length, the copy stops at the destination length and no byte past it is written. The completion code is 1. Equal lengths give code 0.
- R8: The long command is refused with code 3 if src < dst < src + min(dst_len, src_len). In that case nothing is written and the registers hold the loaded operands. A destination below the source, or one starting at src + min, is not an overlap.
- R9: During a long move, `irq` is sampled only before each byte transfer. When it is seen, the engine pulses `irq_ack`, drops `busy` without a `done` pulse, and leaves the registers consistent with the bytes already moved. A `start` with `resume`=1 then finishes the move from those registers.
- R10: `busy` is high from the cycle after `start` through the `done` cycle, `done` lasts one cycle, and memory is written only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted while idle |
| is_long | input | 1 | 1 selects the long command, 0 the short one |
| resume | input | 1 | Long command continues from the held registers instead of loading new operands |
| irq | input | 1 | Interrupt request, honoured by long moves only |
| sh_len | input | 8 | Short command count field N (moves N+1 bytes) |
| ld_dst_addr | input | 24 | Destination address operand |
| ld_dst_len | input | 24 | Destination length operand (long) |
| ld_src_addr | input | 24 | Source address operand |
| ld_src_len | input | 24 | Source length operand (long) |
| ld_pad | input | 8 | Pad byte operand (long) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| irq_ack | output | 1 | One-cycle pulse when a long move stops for an interrupt |
| cc | output | 2 | Completion code: 0 equal, 1 destination shorter, 2 destination longer, 3 overlap |
| reg_dst_addr | output | 24 | Architectural destination address |
| reg_dst_len | output | 24 | Architectural destination length |
| reg_src_addr | output | 24 | Architectural source address |
| reg_src_len | output | 24 | Architectural source length |
| reg_pad | output | 8 | Architectural pad byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read request |

## Verification
The hardest state to reach from the ports is a long move stopped part way. Here the registers hold a partial copy, and the byte at the current destination address must still hold its old value. The bench raises `irq` a few cycles into a twenty-byte move and waits for `irq_ack`. It then checks that the advance of the destination address and the drop in the destination length agree. It checks the memory on both sides of the stopping point, then resumes the move with deliberately wrong operand inputs, which must be ignored. The overlap boundaries are covered as well: a destination just inside the source window, one exactly at its end, and one below the source.

// File: rtl/blkmov_pkg.sv
package blkmov_pkg;
   // Completion codes: the values are visible at the cc port
   typedef enum logic [1:0] {
      CC_EQUAL     = 2'd0,
      CC_DST_SHORT = 2'd1,
      CC_DST_LONG  = 2'd2,
      CC_OVERLAP   = 2'd3
   } bm_code_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SRD,
      ST_SWR,
      ST_LISS,
      ST_LWR,
      ST_FIN
   } bm_state_e;
endpackage

// File: rtl/blkmov_lenclass.sv
module blkmov_lenclass
   import blkmov_pkg::*;
#(
   parameter int LEN_W = 24
) (
   input  logic [LEN_W-1:0] dlen,
   input  logic [LEN_W-1:0] slen,
   output bm_code_e         cls,
   output logic [LEN_W-1:0] span
);
   logic d_lt_s;

   assign d_lt_s = (dlen < slen);
   assign span   = d_lt_s ? dlen : slen;

   always_comb begin
      if (dlen == slen)  cls = CC_EQUAL;
      else if (d_lt_s)   cls = CC_DST_SHORT;
      else               cls = CC_DST_LONG;
   end
endmodule

// File: rtl/blkmov_overlap.sv
module blkmov_overlap #(
   parameter int ADDR_W = 24,
   parameter int LEN_W  = 24,
   parameter bit STRICT = 1'b0
) (
   input  logic [ADDR_W-1:0] src,
   input  logic [ADDR_W-1:0] dst,
   input  logic [LEN_W-1:0]  span,
   output logic              hit
);
   localparam int XW = ADDR_W + 1;

   logic [XW-1:0] span_x;
   logic [XW-1:0] s_end;

   assign span_x = XW'(span);
   assign s_end  = {1'b0, src} + span_x;

   generate
      if (STRICT) begin : g_any
         // refuse any intersection of the two used windows
         logic [XW-1:0] d_end;
         assign d_end = {1'b0, dst} + span_x;
         assign hit   = (span != '0) && ({1'b0, dst} < s_end) && ({1'b0, src} < d_end);
      end else begin : g_fwd
         // refuse only when an ascending copy would overwrite unread source
         assign hit = (dst > src) && ({1'b0, dst} < s_end);
      end
   endgenerate
endmodule

// File: rtl/blkmov_engine.sv
module blkmov_engine
   import blkmov_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int LEN_W      = 24,
   parameter int SH_W       = 8,
   parameter bit STRICT_OVL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_long,
   input  logic              resume,
   input  logic              irq,
   input  logic [SH_W-1:0]   sh_len,
   input  logic [ADDR_W-1:0] ld_dst_addr,
   input  logic [LEN_W-1:0]  ld_dst_len,
   input  logic [ADDR_W-1:0] ld_src_addr,
   input  logic [LEN_W-1:0]  ld_src_len,
   input  logic [7:0]        ld_pad,
   output logic              busy,
   output logic              done,
   output logic              irq_ack,
   output logic [1:0]        cc,
   output logic [ADDR_W-1:0] reg_dst_addr,
   output logic [LEN_W-1:0]  reg_dst_len,
   output logic [ADDR_W-1:0] reg_src_addr,
   output logic [LEN_W-1:0]  reg_src_len,
   output logic [7:0]        reg_pad,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   localparam int CNT_W = SH_W + 1;

   initial begin
      assert (LEN_W <= ADDR_W) else $error("LEN_W must not exceed ADDR_W");
      assert (SH_W >= 1 && SH_W <= LEN_W) else $error("SH_W out of range");
   end

   bm_state_e         st;
   bm_code_e          cc_q;
   logic [ADDR_W-1:0] dst_a, src_a, sh_src, sh_dst;
   logic [LEN_W-1:0]  dst_l, src_l;
   logic [7:0]        pad_q;
   logic [CNT_W-1:0]  sh_cnt;
   logic              ack_q;

   // operands a long command would start from
   logic [ADDR_W-1:0] c_da, c_sa;
   logic [LEN_W-1:0]  c_dl, c_sl, span;
   bm_code_e          cls;
   logic              ovl_hit;

   assign c_da = resume ? dst_a : ld_dst_addr;
   assign c_sa = resume ? src_a : ld_src_addr;
   assign c_dl = resume ? dst_l : ld_dst_len;
   assign c_sl = resume ? src_l : ld_src_len;

   blkmov_lenclass #(.LEN_W(LEN_W)) u_cls (
      .dlen(c_dl), .slen(c_sl), .cls(cls), .span(span)
   );

   blkmov_overlap #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STRICT(STRICT_OVL)) u_ovl (
      .src(c_sa), .dst(c_da), .span(span), .hit(ovl_hit)
   );

   logic l_more, l_go;
   assign l_more = (dst_l != '0);
   assign l_go   = (st == ST_LISS) && l_more && !irq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cc_q   <= CC_EQUAL;
         dst_a  <= '0;
         src_a  <= '0;
         dst_l  <= '0;
         src_l  <= '0;
         pad_q  <= '0;
         sh_src <= '0;
         sh_dst <= '0;
         sh_cnt <= '0;
         ack_q  <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               if (!is_long) begin
                  sh_src <= ld_src_addr;
                  sh_dst <= ld_dst_addr;
                  sh_cnt <= {1'b0, sh_len} + CNT_W'(1);
                  cc_q   <= CC_EQUAL;
                  st     <= ST_SRD;
               end else begin
                  dst_a <= c_da;
                  src_a <= c_sa;
                  dst_l <= c_dl;
                  src_l <= c_sl;
                  if (!resume) pad_q <= ld_pad;
                  if (ovl_hit) begin
                     cc_q <= CC_OVERLAP;
                     st   <= ST_FIN;
                  end else begin
                     cc_q <= cls;
                     st   <= ST_LISS;
                  end
               end
            end
            ST_SRD: st <= ST_SWR;
            ST_SWR: begin
               sh_src <= sh_src + ADDR_W'(1);
               sh_dst <= sh_dst + ADDR_W'(1);
               sh_cnt <= sh_cnt - CNT_W'(1);
               st     <= (sh_cnt == CNT_W'(1)) ? ST_FIN : ST_SRD;
            end
            ST_LISS: begin
               if (!l_more) begin
                  st <= ST_FIN;
               end else if (irq) begin
                  ack_q <= 1'b1;
                  st    <= ST_IDLE;
               end else if (src_l != '0) begin
                  st <= ST_LWR;
               end else begin
                  dst_a <= dst_a + ADDR_W'(1);
                  dst_l <= dst_l - LEN_W'(1);
               end
            end
            ST_LWR: begin
               dst_a <= dst_a + ADDR_W'(1);
               dst_l <= dst_l - LEN_W'(1);
               src_a <= src_a + ADDR_W'(1);
               src_l <= src_l - LEN_W'(1);
               st    <= ST_LISS;
            end
            ST_FIN: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = dst_a;
      mem_wdata = pad_q;
      unique case (st)
         ST_SRD: begin
            mem_req  = 1'b1;
            mem_addr = sh_src;
         end
         ST_SWR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sh_dst;
            mem_wdata = mem_rdata;
         end
         ST_LISS: begin
            mem_req  = l_go;
            mem_we   = l_go && (src_l == '0);
            mem_addr = (src_l != '0) ? src_a : dst_a;
         end
         ST_LWR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = mem_rdata;
         end
         default: ;
      endcase
   end

   assign busy         = (st != ST_IDLE);
   assign done         = (st == ST_FIN);
   assign irq_ack      = ack_q;
   assign cc           = cc_q;
   assign reg_dst_addr = dst_a;
   assign reg_dst_len  = dst_l;
   assign reg_src_addr = src_a;
   assign reg_src_len  = src_l;
   assign reg_pad      = pad_q;

   logic in_short;
   assign in_short = (st == ST_SRD) || (st == ST_SWR);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   // R2
   short_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_short |=> ($stable(dst_a) && $stable(dst_l) && $stable(src_a) && $stable(src_l) && $stable(pad_q)));

   // R3
   short_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_short |=> (busy && !irq_ack));

   // R9
   irq_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (!busy && !done));

   // R5
   long_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LWR) |=> ((dst_l == $past(dst_l) - LEN_W'(1)) && (src_a == $past(src_a) + ADDR_W'(1))));
endmodule

// File: tb/blkmov_engine_test.sv
module blkmov_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, is_long = 1'b0, resume = 1'b0, irq = 1'b0;
   logic [7:0]  sh_len = '0;
   logic [23:0] ld_dst_addr = '0, ld_dst_len = '0, ld_src_addr = '0, ld_src_len = '0;
   logic [7:0]  ld_pad = '0;
   logic        busy, done, irq_ack, mem_req, mem_we;
   logic [1:0]  cc;
   logic [23:0] reg_dst_addr, reg_dst_len, reg_src_addr, reg_src_len, mem_addr;
   logic [7:0]  reg_pad, mem_wdata;
   logic [7:0]  mem_rdata = '0;

   always #10 clk = ~clk;

   blkmov_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .is_long(is_long), .resume(resume), .irq(irq),
      .sh_len(sh_len), .ld_dst_addr(ld_dst_addr), .ld_dst_len(ld_dst_len),
      .ld_src_addr(ld_src_addr), .ld_src_len(ld_src_len), .ld_pad(ld_pad),
      .busy(busy), .done(done), .irq_ack(irq_ack), .cc(cc),
      .reg_dst_addr(reg_dst_addr), .reg_dst_len(reg_dst_len),
      .reg_src_addr(reg_src_addr), .reg_src_len(reg_src_len), .reg_pad(reg_pad),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // memory model: 1 KiB, registered read
   logic [7:0] mem [0:1023];
   logic       init_mem = 1'b0;
   int         wr_cnt = 0;

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 13) + 5);
   endfunction

   always @(posedge clk) begin
      if (init_mem) begin
         for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
      end else if (mem_req && mem_we) begin
         mem[mem_addr[9:0]] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:0]];
   end

   int n_chk = 0, n_fail = 0;
   int writes;
   bit done_seen, ack_seen;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reload();
      @(negedge clk) init_mem = 1'b1;
      @(negedge clk) init_mem = 1'b0;
   endtask

   task automatic issue(input bit lng, input bit res, input logic [7:0] n,
                        input int da, input int dl, input int sa, input int sl,
                        input logic [7:0] pd);
      @(negedge clk);
      is_long = lng; resume = res; sh_len = n;
      ld_dst_addr = 24'(da); ld_dst_len = 24'(dl);
      ld_src_addr = 24'(sa); ld_src_len = 24'(sl); ld_pad = pd;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0; resume = 1'b0;
   endtask

   // waits for done or irq_ack; leaves the engine idle
   task automatic finish_wait();
      int w0;
      w0 = wr_cnt;
      done_seen = 0; ack_seen = 0;
      for (int c = 0; c < 3000; c++) begin
         if (done) done_seen = 1;
         if (irq_ack) ack_seen = 1;
         if (done || irq_ack) break;
         @(negedge clk);
      end
      @(negedge clk);
      writes = wr_cnt - w0;
   endtask

   task automatic t_reset();
      check("R10 reset busy", 32'(busy), 0);
      check("R10 reset done", 32'(done), 0);
      check("R9 reset irq_ack", 32'(irq_ack), 0);
      check("R5 reset dst_len", reg_dst_len, 0);
   endtask

   task automatic t_long_equal();
      reload();
      issue(1, 0, 0, 'h300, 16, 'h020, 16, 8'hAA);
      check("R10 busy after start", 32'(busy), 1);
      finish_wait();
      check("R10 done seen", 32'(done_seen), 1);
      check("R10 done one cycle", 32'(done), 0);
      check("R7 equal code", 32'(cc), 0);
      for (int k = 0; k < 16; k++) check("R5 copy data", mem['h300 + k], pat('h020 + k));
      check("R5 past end untouched", mem['h310], pat('h310));
      check("R5 dst_addr", reg_dst_addr, 'h310);
      check("R5 dst_len", reg_dst_len, 0);
      check("R5 src_addr", reg_src_addr, 'h030);
      check("R5 src_len", reg_src_len, 0);
   endtask

   task automatic t_short(input int n);
      logic [23:0] da, dl, sa, sl;
      logic [7:0]  pd;
      reload();
      da = reg_dst_addr; dl = reg_dst_len; sa = reg_src_addr; sl = reg_src_len; pd = reg_pad;
      issue(0, 0, 8'(n), 'h200, 99, 'h010, 77, 8'h11);
      finish_wait();
      check("R1 short done", 32'(done_seen), 1);
      check("R2 short code", 32'(cc), 0);
      check("R1 short write count", writes, n + 1);
      for (int k = 0; k <= n; k++) check("R1 short data", mem['h200 + k], pat('h010 + k));
      check("R1 byte after field", mem['h200 + n + 1], pat('h200 + n + 1));
      check("R2 dst_addr kept", reg_dst_addr, da);
      check("R2 dst_len kept", reg_dst_len, dl);
      check("R2 src_addr kept", reg_src_addr, sa);
      check("R2 src_len kept", reg_src_len, sl);
      check("R2 pad kept", reg_pad, pd);
   endtask

   task automatic t_pad();
      reload();
      issue(1, 0, 0, 'h300, 10, 'h040, 4, 8'h5C);
      finish_wait();
      check("R6 code dst longer", 32'(cc), 2);
      for (int k = 0; k < 4; k++) check("R6 copied part", mem['h300 + k], pat('h040 + k));
      for (int k = 4; k < 10; k++) check("R6 pad fill", mem['h300 + k], 8'h5C);
      check("R6 past end untouched", mem['h30A], pat('h30A));
      check("R6 src_addr", reg_src_addr, 'h044);
      check("R6 dst_addr", reg_dst_addr, 'h30A);
   endtask

   task automatic t_trunc();
      reload();
      issue(1, 0, 0, 'h300, 5, 'h050, 9, 8'h77);
      finish_wait();
      check("R7 code dst shorter", 32'(cc), 1);
      check("R7 write count", writes, 5);
      for (int k = 0; k < 5; k++) check("R7 copied part", mem['h300 + k], pat('h050 + k));
      check("R7 no write past dst", mem['h305], pat('h305));
      check("R7 src_len remainder", reg_src_len, 4);
      check("R7 src_addr", reg_src_addr, 'h055);
   endtask

   task automatic t_zero();
      reload();
      issue(1, 0, 0, 'h300, 0, 'h060, 3, 8'h00);
      finish_wait();
      check("R4 zero done", 32'(done_seen), 1);
      check("R4 zero writes", writes, 0);
      check("R4 zero code", 32'(cc), 1);
      check("R4 dst_addr kept", reg_dst_addr, 'h300);
      check("R4 src_len kept", reg_src_len, 3);
      issue(1, 0, 0, 'h310, 0, 'h060, 0, 8'h00);
      finish_wait();
      check("R4 both zero code", 32'(cc), 0);
      check("R4 both zero writes", writes, 0);
   endtask

   task automatic t_overlap();
      reload();
      issue(1, 0, 0, 'h104, 8, 'h100, 8, 8'h33);
      finish_wait();
      check("R8 overlap code", 32'(cc), 3);
      check("R8 overlap no writes", writes, 0);
      check("R8 overlap done", 32'(done_seen), 1);
      check("R8 regs dst_len", reg_dst_len, 8);
      check("R8 regs dst_addr", reg_dst_addr, 'h104);
      check("R8 regs src_addr", reg_src_addr, 'h100);
      issue(1, 0, 0, 'h108, 8, 'h100, 8, 8'h33);
      finish_wait();
      check("R8 at window end allowed", 32'(cc), 0);
      check("R8 at window end writes", writes, 8);
      reload();
      issue(1, 0, 0, 'h0FC, 8, 'h100, 8, 8'h33);
      finish_wait();
      check("R8 dst below src allowed", 32'(cc), 0);
      for (int k = 0; k < 8; k++) check("R8 downward copy data", mem['h0FC + k], pat('h100 + k));
   endtask

   task automatic t_irq();
      int moved;
      reload();
      issue(1, 0, 0, 'h380, 20, 'h060, 20, 8'hEE);
      repeat (9) @(negedge clk);
      irq = 1'b1;
      finish_wait();
      irq = 1'b0;
      moved = 20 - int'(reg_dst_len);
      check("R9 irq_ack seen", 32'(ack_seen), 1);
      check("R9 no done on stop", 32'(done_seen), 0);
      check("R9 busy low", 32'(busy), 0);
      check("R9 partial progress", 32'(moved > 0 && moved < 20), 1);
      check("R9 dst_addr consistent", reg_dst_addr, 'h380 + moved);
      check("R9 src_addr consistent", reg_src_addr, 'h060 + moved);
      check("R9 src_len consistent", reg_src_len, 20 - moved);
      check("R9 last moved byte", mem['h380 + moved - 1], pat('h060 + moved - 1));
      check("R9 next byte untouched", mem['h380 + moved], pat('h380 + moved));
      issue(1, 1, 0, 'h000, 3, 'h000, 1, 8'h00);
      finish_wait();
      check("R9 resume done", 32'(done_seen), 1);
      check("R9 resume code", 32'(cc), 0);
      for (int k = 0; k < 20; k++) check("R9 full data", mem['h380 + k], pat('h060 + k));
      check("R9 final dst_addr", reg_dst_addr, 'h394);
      check("R9 final src_len", reg_src_len, 0);
   endtask

   task automatic t_short_irq();
      reload();
      irq = 1'b1;
      issue(0, 0, 8'd7, 'h200, 0, 'h010, 0, 8'h00);
      finish_wait();
      irq = 1'b0;
      check("R3 short done with irq", 32'(done_seen), 1);
      check("R3 short no irq_ack", 32'(ack_seen), 0);
      check("R3 short writes", writes, 8);
      check("R3 short last byte", mem['h207], pat('h017));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_long_equal();
      t_short(0);
      t_short(255);
      t_pad();
      t_trunc();
      t_zero();
      t_overlap();
      t_irq();
      t_short_irq();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule